// File: doc/BRIEF.md
# Motor Stall Protection Watchdog

This block watches a running motor and removes the high-side drive when the motor looks stalled. One of two stall criteria is chosen by a select input. The first is a lock indicator that stays in the unlocked state. The second is a speed-feedback signal that stops changing level. Whichever criterion is chosen, the stall condition has to last for a programmable number of prescaled clock ticks while the run command is asserted. A held deceleration input restarts the count, so a deliberate slow-down caused by lowering the reference clock cannot trip the watchdog. If the reference clock is lost, the lock indicator drops and the lock criterion eventually trips.

A trip latches a fault. While the fault is set, every high-side enable coming out of the block is forced low. Only the run command returning to stop, or a reset, clears the fault. The counter saturates and never wraps, so a long stall cannot drop out of the tripped state by rolling the count over.

Top module: `stall_guard`

## Requirements
- R1: After reset, `fault` is 0 and `hs_gate` equals `hs_req`.
- R2: With `crit_sel` = 1, the count restarts in every cycle where `lock_ok` = 1. `fault` rises once `lock_ok` has stayed 0 long enough for the count to reach `timeout`.
- R3: With `crit_sel` = 0, any change of `fb_in` between two consecutive clock samples restarts the count. The first sample after reset is compared against 0. `lock_ok` has no effect in this mode.
- R4: While `run_req` = 0, the count is held at zero and `fault` is cleared at the next clock edge. No trip can happen.
- R5: Once set, `fault` stays at 1 while `run_req` = 1, whatever `lock_ok`, `fb_in`, `decel_hold` and `crit_sel` do.
- R6: While `fault` = 1, `hs_gate` is all zeros. Otherwise `hs_gate` equals `hs_req` in the same cycle.
- R7: While `decel_hold` = 1, the count is restarted and no new fault can be set.
- R8: The count saturates at its all-ones value. A `timeout` equal to that maximum still trips.
- R9: The count advances by at most one per prescaler tick, and a tick comes once every `PRESC_DIV` clocks. `fault` is set at the clock edge after the count has reached `timeout` with no restart in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req | input | 1 | 1 = start (run), 0 = stop |
| crit_sel | input | 1 | Stall criterion: 1 = lock indicator, 0 = feedback edges |
| lock_ok | input | 1 | Lock indicator, 1 = locked |
| fb_in | input | 1 | Speed feedback level, already synchronous to clk |
| decel_hold | input | 1 | 1 while a deliberate deceleration is in progress |
| timeout | input | CNT_W | Stall timeout in prescaled ticks |
| hs_req | input | PHASES | Requested high-side enables |
| hs_gate | output | PHASES | High-side enables after fault gating |
| fault | output | 1 | Latched stall fault |

## Verification
The bench builds the block with `CNT_W` = 6, `PRESC_DIV` = 3 and `PHASES` = 3. With a six-bit count, a `timeout` at the saturation value of 63 trips within about two hundred cycles, so both the saturation corner and a full-length stall can be reached. A divide-by-three prescaler means the trip instant depends on the prescaler phase. The per-cycle reference model therefore checks that tick alignment in every cycle of every scenario.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;
   typedef enum logic {
      CRIT_EDGE = 1'b0,
      CRIT_LOCK = 1'b1
   } crit_e;
endpackage

// File: rtl/stall_tick.sv
module stall_tick #(
   parameter int PRESC_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

   generate
      if (PRESC_DIV < 1) begin : g_bad_div
         $error("stall_tick: PRESC_DIV must be at least 1");
      end
      if (PRESC_DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_div
         localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
         logic [PW-1:0] pc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pc <= '0;
            else if (pc == LAST) pc <= '0;
            else                 pc <= pc + 1'b1;
         end
         assign tick = (pc == LAST);

         // R9: the tick is never asserted in two consecutive cycles
         p_tick_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/stall_activity.sv
module stall_activity
   import stall_guard_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic run_req,
   input  logic crit_sel,
   input  logic lock_ok,
   input  logic fb_in,
   input  logic decel_hold,
   output logic restart
);
   logic fb_q;
   logic fb_edge;
   logic alive;
   crit_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fb_q <= 1'b0;
      else        fb_q <= fb_in;
   end

   assign fb_edge = fb_in ^ fb_q;
   assign mode    = crit_e'(crit_sel);

   always_comb begin
      unique case (mode)
         CRIT_LOCK: alive = lock_ok;
         default:   alive = fb_edge;
      endcase
   end

   assign restart = !run_req || decel_hold || alive;

   // R3: a change of feedback level seen across two samples restarts the count
   p_edge_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_req && !crit_sel && $past(rst_n) && (fb_in != $past(fb_in))) |-> restart);
endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic             run_req,
   input  logic [CNT_W-1:0] timeout,
   output logic             fault
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic             expired;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("stall_timer: CNT_W must be at least 2");
      end
   endgenerate

   assign expired = !restart && (cnt >= timeout);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (restart)                cnt <= '0;
      else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fault <= 1'b0;
      else if (!run_req) fault <= 1'b0;
      else if (expired)  fault <= 1'b1;
   end

   // R4: stop clears the fault on the following edge
   p_stop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run_req |=> !fault);
   // R5: the fault is held while running
   p_fault_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && run_req) |=> fault);
   // R8: no wrap of the count at its maximum
   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt == CNT_MAX) && !restart) |=> (cnt == CNT_MAX));
   // R9: the count steps by at most one
   p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));
   // R2: a rising fault needs an expired count in the cycle before
   p_trip_needs_expiry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault) |-> $past(cnt >= timeout));
endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
   parameter int CNT_W     = 16,
   parameter int PRESC_DIV = 4,
   parameter int PHASES    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_req,
   input  logic              crit_sel,
   input  logic              lock_ok,
   input  logic              fb_in,
   input  logic              decel_hold,
   input  logic [CNT_W-1:0]  timeout,
   input  logic [PHASES-1:0] hs_req,
   output logic [PHASES-1:0] hs_gate,
   output logic              fault
);
   logic tick;
   logic restart;

   generate
      if (PHASES < 1) begin : g_bad_ph
         $error("stall_guard: PHASES must be at least 1");
      end
   endgenerate

   stall_tick #(.PRESC_DIV(PRESC_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   stall_activity u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_req   (run_req),
      .crit_sel  (crit_sel),
      .lock_ok   (lock_ok),
      .fb_in     (fb_in),
      .decel_hold(decel_hold),
      .restart   (restart)
   );

   stall_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .restart(restart),
      .run_req(run_req),
      .timeout(timeout),
      .fault  (fault)
   );

   generate
      for (genvar g = 0; g < PHASES; g++) begin : g_gate
         assign hs_gate[g] = hs_req[g] & ~fault;
      end
   endgenerate

   // R6: no high-side enable passes while faulted
   p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (hs_gate == '0));
   // R7: a held deceleration never sets a new fault
   p_hold_no_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (decel_hold && !fault) |=> !fault);
endmodule

// File: tb/test_stall_guard.sv
`timescale 1ns/100ps
module test_stall_guard;
   localparam int CNT_W = 6;
   localparam int DIV   = 3;
   localparam int PH    = 3;
   localparam int MAXC  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_req = 1'b0, crit_sel = 1'b1, lock_ok = 1'b0, fb_in = 1'b0, decel_hold = 1'b0;
   logic [CNT_W-1:0] timeout = 6'd5;
   logic [PH-1:0] hs_req = 3'b101;
   logic [PH-1:0] hs_gate;
   logic fault;

   int n_cmp = 0, n_bad = 0, n_cyc = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   int m_pc = 0, m_cnt = 0;
   bit m_fault = 1'b0, m_prev = 1'b0;

   always #2.5 clk = ~clk;

   stall_guard #(.CNT_W(CNT_W), .PRESC_DIV(DIV), .PHASES(PH)) i_stall_guard (
      .clk(clk), .rst_n(rst_n), .run_req(run_req), .crit_sel(crit_sel),
      .lock_ok(lock_ok), .fb_in(fb_in), .decel_hold(decel_hold),
      .timeout(timeout), .hs_req(hs_req), .hs_gate(hs_gate), .fault(fault));

   // behavioural reference, advanced at each rising edge
   always @(posedge clk) begin
      bit tk, act, rs, trip;
      if (!rst_n) begin
         m_pc = 0; m_cnt = 0; m_fault = 0; m_prev = 0;
      end else begin
         tk   = (m_pc == DIV - 1);
         m_pc = tk ? 0 : m_pc + 1;
         act  = crit_sel ? lock_ok : (fb_in != m_prev);
         rs   = !run_req || decel_hold || act;
         trip = !rs && (m_cnt >= int'(timeout));
         m_fault = !run_req ? 1'b0 : (m_fault || trip);
         if (rs) m_cnt = 0;
         else if (tk && m_cnt < MAXC) m_cnt = m_cnt + 1;
         m_prev = fb_in;
      end
   end

   // per-cycle comparison away from the edge
   always @(posedge clk) begin
      logic [PH-1:0] exp_g;
      #2;
      if (!done) begin
         exp_g = m_fault ? '0 : hs_req;
         n_cmp++;
         if (fault !== m_fault || hs_gate !== exp_g) begin
            n_bad++;
            $display("FAIL %s per-cycle: fault=%b gate=%b expected fault=%b gate=%b",
                     cur_req, fault, hs_gate, m_fault, exp_g);
         end
         n_cyc++;
         if (n_cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", n_cyc);
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit exp_f, input string tag);
      n_cmp++;
      if (fault !== exp_f || hs_gate !== (exp_f ? '0 : hs_req)) begin
         n_bad++;
         $display("FAIL %s: fault=%b gate=%b expected fault=%b gate=%b",
                  tag, fault, hs_gate, exp_f, exp_f ? 3'b000 : hs_req);
      end
   endtask

   initial begin
      cyc(3);
      chk(1'b0, "R1 during reset");
      rst_n = 1'b1;
      cyc(2);
      chk(1'b0, "R1 after reset");

      // R4: stopped, no activity for long: no trip
      cur_req = "R4"; lock_ok = 1'b0; crit_sel = 1'b1;
      cyc(40);
      chk(1'b0, "R4 no trip while stopped");

      // R2: lock criterion
      cur_req = "R2"; run_req = 1'b1;
      cyc(10); lock_ok = 1'b1; cyc(1); lock_ok = 1'b0; cyc(10);
      chk(1'b0, "R2 lock pulse restarts count");
      cyc(20);
      chk(1'b1, "R2 trip after unlocked timeout");

      // R5/R6: fault latched, gating
      cur_req = "R5"; hs_req = 3'b111; lock_ok = 1'b1; decel_hold = 1'b1;
      fb_in = 1'b1; cyc(3); fb_in = 1'b0; crit_sel = 1'b0; cyc(5);
      chk(1'b1, "R5 fault stays latched");
      cur_req = "R6"; hs_req = 3'b011; cyc(1);
      chk(1'b1, "R6 gates all high side off");

      // R4: stop clears
      cur_req = "R4"; run_req = 1'b0; decel_hold = 1'b0; cyc(1);
      chk(1'b0, "R4 stop clears fault");

      // R3: edge criterion, lock low ignored
      cur_req = "R3"; crit_sel = 1'b0; lock_ok = 1'b0; run_req = 1'b1;
      for (int k = 0; k < 10; k++) begin
         cyc(6); fb_in = ~fb_in;
      end
      chk(1'b0, "R3 toggling feedback keeps running");
      cyc(30);
      chk(1'b1, "R3 trip when feedback stops");
      run_req = 1'b0; cyc(2); run_req = 1'b1;

      // R7: deceleration hold
      cur_req = "R7"; decel_hold = 1'b1;
      cyc(60);
      chk(1'b0, "R7 hold suppresses trip");
      decel_hold = 1'b0; cyc(30);
      chk(1'b1, "R7 trip after hold released");
      run_req = 1'b0; cyc(2);

      // R9: short timeout, exact alignment checked per cycle
      cur_req = "R9"; timeout = 6'd2; run_req = 1'b1;
      cyc(3);
      chk(1'b0, "R9 not before two ticks");
      cyc(10);
      chk(1'b1, "R9 trip after two ticks");
      run_req = 1'b0; cyc(1); run_req = 1'b1; cyc(1);
      timeout = 6'd0; cyc(2);
      chk(1'b1, "R9 zero timeout trips at once");
      run_req = 1'b0; cyc(2);

      // R8: maximum timeout, saturation
      cur_req = "R8"; timeout = 6'd63; crit_sel = 1'b1; lock_ok = 1'b0; run_req = 1'b1;
      cyc(150);
      chk(1'b0, "R8 not before maximum timeout");
      cyc(60);
      chk(1'b1, "R8 trip at maximum timeout");
      cyc(40);
      chk(1'b1, "R8 stays tripped past saturation");

      // R1: reset clears a latched fault
      cur_req = "R1"; rst_n = 1'b0; cyc(2);
      chk(1'b0, "R1 reset clears fault");
      rst_n = 1'b1; run_req = 1'b0; cyc(3);
      chk(1'b0, "R1 idle after reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule